// File: doc/BRIEF.md
# Rectangle Copy Blit Engine

This block moves a rectangle of pixels from one surface to another in a flat, byte-addressed memory. Software describes both surfaces and the copy through a stream of method writes. Each write carries a 3-bit method selector and a 32-bit argument. The surface setup is the pixel format, the two pitches and the two base offsets. The copy setup is the operation, the source corner, the destination corner and the extent. Writing the extent method launches the copy.

The engine walks the rectangle one row at a time, in ascending row order. Inside a row it moves one byte per read/write pair on a single memory master port. Before each row it compares the destination row address with the source row address. It then walks the row from the top down when the destination lies above the source, and from the bottom up otherwise. This way a row that overlaps itself ends up holding the original source bytes. The method port is a valid/ready stream. `mth_ready` stays low for the whole copy, so a write offered during a copy is held by the sender and takes effect only after the copy ends. A bad setup raises a one-cycle `fault` instead of starting. A finished copy raises a one-cycle `done`.

Top module: `blit_engine`

## Requirements
- R1: `mth_ready` is high exactly when the engine is idle. A method offered while a copy runs is not accepted until the copy has finished. Its value applies only to launches after that point.
- R2: Method selector 1 (pitch) takes the source pitch from bits 15:0 and the destination pitch from bits 31:16.
- R3: Selectors 5 (source corner), 6 (destination corner) and 7 (extent) each take X or width from bits 15:0 and Y or height from bits 31:16. Selector 0 is the format, 2 the source offset, 3 the destination offset and 4 the operation.
- R4: Format code 0x01 means 1 byte per pixel and code 0x0A means 4 bytes per pixel. An extent write with any other stored format raises `fault` for one cycle and causes no memory traffic.
- R5: An extent write starts a copy only when the stored operation equals 3. Any other operation raises `fault` and causes no memory traffic.
- R6: An extent write raises `fault`, with no traffic, unless the source offset is below `lim_src` and the destination offset is below `lim_dst`. An offset of exactly limit-1 is legal.
- R7: Row r reads from source_offset + (src_y + r) * source_pitch + src_x * bpp. It writes to the same form built from the destination offset, pitch and corner.
- R8: Each row moves width * bpp bytes, for height rows in ascending r, one read followed by one write per byte.
- R9: In a row whose destination address is above its source address, bytes go from the highest index down; otherwise from the lowest up. The destination receives the row's original source bytes even when the two ranges overlap.
- R10: `busy` is high from the cycle after a launching extent write until the copy ends. `done` is high for exactly one cycle, the cycle after the last write.
- R11: An extent write with width 0 or height 0, and no fault, raises `done` in the next cycle with no memory traffic.
- R12: After reset `busy`, `done`, `fault`, `mem_rd_en` and `mem_wr_en` are low and `mth_ready` is high. All setup values are zero, so an immediate extent write faults (format 0).
- R13: Memory reads have a latency of one cycle. The write of each byte follows its read in the next cycle and carries `mem_rdata` of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mth_valid | input | 1 | Method write offered |
| mth_ready | output | 1 | Method write accepted when high with valid |
| mth_sel | input | 3 | Method selector |
| mth_data | input | 32 | Method argument |
| lim_src | input | AW | Source region limit (exclusive) |
| lim_dst | input | AW | Destination region limit (exclusive) |
| mem_rd_en | output | 1 | Byte read request |
| mem_wr_en | output | 1 | Byte write request |
| mem_addr | output | AW | Byte address for the read or write |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid the cycle after the request |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle copy completion pulse |
| fault | output | 1 | One-cycle launch rejection pulse |

## Verification
The hardest case to reach is a row that overlaps itself in each direction. It needs a single surface and corners a few bytes apart, so that a wrong walk order overwrites bytes before they are read. The bench places source and destination at the same offset and shifts the corner right for a top-down row. It then shifts the corner left for a bottom-up row, and checks every write against a memmove model of that row. The back-pressure case is reached by offering an operation change while a long copy runs. The bench then proves the change applied only afterwards, because the next launch faults.

// File: rtl/blit_pkg.sv
package blit_pkg;
  localparam int unsigned CRD = 16;
  localparam int unsigned DB  = 8;

  typedef enum logic [2:0] {
    M_FMT    = 3'd0,
    M_PITCH  = 3'd1,
    M_SRCOFF = 3'd2,
    M_DSTOFF = 3'd3,
    M_OP     = 3'd4,
    M_PIN    = 3'd5,
    M_POUT   = 3'd6,
    M_SIZE   = 3'd7
  } meth_e;

  localparam logic [7:0]  FMT_1B  = 8'h01;
  localparam logic [7:0]  FMT_4B  = 8'h0A;
  localparam logic [31:0] OP_COPY = 32'd3;

  typedef enum logic [1:0] {ST_IDLE, ST_ROW, ST_RD, ST_WR} seq_st_e;

  typedef struct packed {
    logic [CRD-1:0] y;
    logic [CRD-1:0] x;
  } xy_t;
endpackage

// File: rtl/blit_regs.sv
module blit_regs
  import blit_pkg::*;
#(
  parameter int unsigned AW = 24
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           acc,
  input  meth_e          m_sel,
  input  logic [31:0]    m_data,
  input  logic [AW-1:0]  lim_src,
  input  logic [AW-1:0]  lim_dst,
  output logic [1:0]     bpp_sh,
  output logic [CRD-1:0] sp,
  output logic [CRD-1:0] dp,
  output logic [AW-1:0]  so,
  output logic [AW-1:0]  dst_o,
  output xy_t            pin,
  output xy_t            pout,
  output xy_t            size,
  output logic           l_go,
  output logic           l_zero,
  output logic           l_fault
);
  logic [7:0]  fmt_q;
  logic [31:0] op_q;
  xy_t         new_size;
  logic        is_size, fmt_ok, op_ok, lim_ok, empty, ok;

  assign new_size = xy_t'(m_data);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fmt_q <= '0;
      op_q  <= '0;
      sp    <= '0;
      dp    <= '0;
      so    <= '0;
      dst_o <= '0;
      pin   <= '0;
      pout  <= '0;
      size  <= '0;
    end else if (acc) begin
      case (m_sel)
        M_FMT:    fmt_q <= m_data[7:0];
        M_PITCH: begin
          sp <= m_data[15:0];
          dp <= m_data[31:16];
        end
        M_SRCOFF: so    <= m_data[AW-1:0];
        M_DSTOFF: dst_o <= m_data[AW-1:0];
        M_OP:     op_q  <= m_data;
        M_PIN:    pin   <= xy_t'(m_data);
        M_POUT:   pout  <= xy_t'(m_data);
        M_SIZE:   size  <= new_size;
        default:  ;
      endcase
    end
  end

  always_comb begin
    fmt_ok  = (fmt_q == FMT_1B) || (fmt_q == FMT_4B);
    op_ok   = (op_q == OP_COPY);
    lim_ok  = (so < lim_src) && (dst_o < lim_dst);
    ok      = fmt_ok && op_ok && lim_ok;
    is_size = acc && (m_sel == M_SIZE);
    empty   = (new_size.x == '0) || (new_size.y == '0);
    l_fault = is_size && !ok;
    l_zero  = is_size && ok && empty;
    l_go    = is_size && ok && !empty;
    bpp_sh  = (fmt_q == FMT_4B) ? 2'd2 : 2'd0;
  end
endmodule

// File: rtl/blit_rowaddr.sv
module blit_rowaddr
  import blit_pkg::*;
#(
  parameter int unsigned AW = 24
) (
  input  logic [AW-1:0]  base,
  input  logic [CRD-1:0] pitch,
  input  xy_t            pt,
  input  logic [1:0]     bpp_sh,
  input  logic [CRD-1:0] row,
  output logic [AW-1:0]  addr
);
  localparam int unsigned PW = 2*CRD + 4;
  logic [PW-1:0] lin;

  always_comb begin
    lin  = (PW'(pt.y) + PW'(row)) * PW'(pitch) + (PW'(pt.x) << bpp_sh);
    addr = base + AW'(lin);
  end
endmodule

// File: rtl/blit_seq.sv
module blit_seq
  import blit_pkg::*;
#(
  parameter int unsigned AW = 24
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go,
  input  logic           zero,
  input  logic           fault_in,
  input  logic [AW-1:0]  src_row,
  input  logic [AW-1:0]  dst_row,
  input  logic [1:0]     bpp_sh,
  input  logic [CRD-1:0] width,
  input  logic [CRD-1:0] height,
  input  logic [DB-1:0]  rdata,
  output logic [CRD-1:0] row,
  output logic           busy,
  output logic           done,
  output logic           fault,
  output logic           rd_en,
  output logic           wr_en,
  output logic [AW-1:0]  addr,
  output logic [DB-1:0]  wdata
);
  localparam int unsigned BW = CRD + 2;

  seq_st_e       st;
  logic [BW-1:0] cnt_q, nbytes, off;
  logic [AW-1:0] sb_q, db_q;
  logic          dsc_q, last_byte, last_row;

  assign nbytes    = BW'(width) << bpp_sh;
  assign off       = dsc_q ? (nbytes - BW'(1) - cnt_q) : cnt_q;
  assign last_byte = (cnt_q == nbytes - BW'(1));
  assign last_row  = (row == height - CRD'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      row   <= '0;
      cnt_q <= '0;
      sb_q  <= '0;
      db_q  <= '0;
      dsc_q <= 1'b0;
      done  <= 1'b0;
      fault <= 1'b0;
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (go) begin
            st  <= ST_ROW;
            row <= '0;
          end else if (zero) begin
            done <= 1'b1;
          end else if (fault_in) begin
            fault <= 1'b1;
          end
        end
        ST_ROW: begin
          sb_q  <= src_row;
          db_q  <= dst_row;
          dsc_q <= (dst_row > src_row);
          cnt_q <= '0;
          st    <= ST_RD;
        end
        ST_RD: st <= ST_WR;
        ST_WR: begin
          if (last_byte) begin
            cnt_q <= '0;
            if (last_row) begin
              st   <= ST_IDLE;
              done <= 1'b1;
            end else begin
              row <= row + 1'b1;
              st  <= ST_ROW;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
            st    <= ST_RD;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy  = (st != ST_IDLE);
  assign rd_en = (st == ST_RD);
  assign wr_en = (st == ST_WR);
  assign addr  = ((st == ST_WR) ? db_q : sb_q) + AW'(off);
  assign wdata = rdata;

  // R8: an accepted launch makes the engine busy in the next cycle
  assert_go_starts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> busy);
  // R10: a completion pulse after a copy follows a write and leaves the engine idle
  assert_done_after_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(busy)) |-> ($past(wr_en) && !busy));
  // R11: an empty extent completes at once without traffic
  assert_zero_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    zero |=> (done && !busy && !rd_en));
  // R13: every write directly follows its read
  assert_wr_follows_rd_R13: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(rd_en));
endmodule

// File: rtl/blit_engine.sv
module blit_engine
  import blit_pkg::*;
#(
  parameter int unsigned AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mth_valid,
  output logic          mth_ready,
  input  logic [2:0]    mth_sel,
  input  logic [31:0]   mth_data,
  input  logic [AW-1:0] lim_src,
  input  logic [AW-1:0] lim_dst,
  output logic          mem_rd_en,
  output logic          mem_wr_en,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata,
  output logic          busy,
  output logic          done,
  output logic          fault
);
  localparam int unsigned NSIDE = 2;

  logic           acc, l_go, l_zero, l_fault;
  logic [1:0]     bpp_sh;
  logic [CRD-1:0] sp, dp, row;
  logic [AW-1:0]  so, dst_o;
  xy_t            pin, pout, size;

  logic [AW-1:0]  base_a  [NSIDE];
  logic [CRD-1:0] pitch_a [NSIDE];
  xy_t            pt_a    [NSIDE];
  logic [AW-1:0]  row_a   [NSIDE];

  assign mth_ready = !busy;
  assign acc       = mth_valid && mth_ready;

  blit_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .acc(acc), .m_sel(meth_e'(mth_sel)), .m_data(mth_data),
    .lim_src(lim_src), .lim_dst(lim_dst), .bpp_sh(bpp_sh), .sp(sp), .dp(dp),
    .so(so), .dst_o(dst_o), .pin(pin), .pout(pout), .size(size),
    .l_go(l_go), .l_zero(l_zero), .l_fault(l_fault)
  );

  assign base_a[0]  = so;
  assign base_a[1]  = dst_o;
  assign pitch_a[0] = sp;
  assign pitch_a[1] = dp;
  assign pt_a[0]    = pin;
  assign pt_a[1]    = pout;

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    blit_rowaddr #(.AW(AW)) u_ra (
      .base(base_a[s]), .pitch(pitch_a[s]), .pt(pt_a[s]),
      .bpp_sh(bpp_sh), .row(row), .addr(row_a[s])
    );
  end

  blit_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(l_go), .zero(l_zero), .fault_in(l_fault),
    .src_row(row_a[0]), .dst_row(row_a[1]), .bpp_sh(bpp_sh),
    .width(size.x), .height(size.y), .rdata(mem_rdata), .row(row),
    .busy(busy), .done(done), .fault(fault), .rd_en(mem_rd_en), .wr_en(mem_wr_en),
    .addr(mem_addr), .wdata(mem_wdata)
  );

  // R4 R5 R6: a rejected launch pulses fault and never starts the copy
  assert_fault_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    l_fault |=> (fault && !busy));
endmodule

// File: tb/test_blit_engine.sv
module test_blit_engine;
  import blit_pkg::*;
  localparam int CLK_NS = 10;
  localparam int AW     = 24;
  localparam int MEMSZ  = 4096;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mth_valid, mth_ready;
  logic [2:0] mth_sel;
  logic [31:0] mth_data;
  logic [AW-1:0] lim_src, lim_dst, mem_addr;
  logic mem_rd_en, mem_wr_en, busy, done, fault;
  logic [7:0] mem_wdata, mem_rdata;

  always #(CLK_NS/2) clk = ~clk;

  blit_engine #(.AW(AW)) i_blit_engine (
    .clk(clk), .rst_n(rst_n), .mth_valid(mth_valid), .mth_ready(mth_ready),
    .mth_sel(mth_sel), .mth_data(mth_data), .lim_src(lim_src), .lim_dst(lim_dst),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy), .done(done), .fault(fault)
  );

  logic [7:0] mem  [MEMSZ];
  logic [7:0] gold [MEMSZ];
  logic mem_fill = 1'b1;
  int n_chk = 0, n_fail = 0;
  int q_rd[$], q_wa[$], q_wd[$];

  function automatic logic [7:0] pat(int i);
    return 8'((i * 7 + 3) ^ (i >> 5));
  endfunction

  always @(posedge clk) begin
    if (mem_fill) begin
      for (int i = 0; i < MEMSZ; i++) mem[i] <= pat(i);
      mem_rdata <= 8'h00;
    end else begin
      if (mem_rd_en) mem_rdata <= mem[mem_addr[11:0]];
      if (mem_wr_en) mem[mem_addr[11:0]] <= mem_wdata;
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // cycle-by-cycle comparison of memory traffic against the reference queues
  always @(negedge clk) begin
    int e;
    if (rst_n) begin
      if (mem_rd_en) begin
        if (q_rd.size() == 0) chk(0, "R11", "unexpected read", int'(mem_addr), -1);
        else begin
          e = q_rd.pop_front();
          chk(int'(mem_addr) == e, "R7", "read address", int'(mem_addr), e);
        end
      end
      if (mem_wr_en) begin
        if (q_wa.size() == 0) chk(0, "R11", "unexpected write", int'(mem_addr), -1);
        else begin
          e = q_wa.pop_front();
          chk(int'(mem_addr) == e, "R9", "write address order", int'(mem_addr), e);
          e = q_wd.pop_front();
          chk(int'(mem_wdata) == e, "R13", "write data", int'(mem_wdata), e);
        end
      end
    end
  end

  task automatic model_copy(int bsh, int sp, int dp, int so, int dof,
                            int ix, int iy, int ox, int oy, int w, int h);
    int bpp, nb, sr, dr, idx;
    logic [7:0] tmp[$];
    bpp = 1 << bsh;
    nb  = w * bpp;
    for (int r = 0; r < h; r++) begin
      sr = so + (iy + r) * sp + ix * bpp;
      dr = dof + (oy + r) * dp + ox * bpp;
      tmp.delete();
      for (int k = 0; k < nb; k++) tmp.push_back(gold[sr + k]);
      for (int k = 0; k < nb; k++) begin
        idx = (dr > sr) ? (nb - 1 - k) : k;
        q_rd.push_back(sr + idx);
        q_wa.push_back(dr + idx);
        q_wd.push_back(int'(tmp[idx]));
      end
      for (int k = 0; k < nb; k++) gold[dr + k] = tmp[k];
    end
  endtask

  task automatic put(meth_e sel, logic [31:0] d);
    @(negedge clk);
    mth_valid = 1'b1;
    mth_sel   = sel;
    mth_data  = d;
    while (!mth_ready) @(negedge clk);
    @(negedge clk);
    mth_valid = 1'b0;
  endtask

  task automatic mem_cmp(string req);
    int bad = 0;
    for (int i = 0; i < MEMSZ; i++) if (mem[i] !== gold[i]) bad++;
    chk(bad == 0, req, "memory image mismatches", bad, 0);
  endtask

  task automatic wait_done(string req);
    int t = 0;
    while (!done && t < 20000) begin
      @(negedge clk);
      t++;
    end
    chk(done == 1'b1, req, "done raised", int'(done), 1);
    chk(busy == 1'b0, req, "idle at done", int'(busy), 0);
    @(negedge clk);
    chk(done == 1'b0, "R10", "done lasts one cycle", int'(done), 0);
    chk(q_rd.size() + q_wa.size() == 0, "R8", "all bytes moved", q_rd.size() + q_wa.size(), 0);
    mem_cmp(req);
  endtask

  task automatic expect_fault(string req);
    chk(fault == 1'b1, req, "fault pulse", int'(fault), 1);
    chk(busy == 1'b0, req, "no copy started", int'(busy), 0);
    @(negedge clk);
    chk(fault == 1'b0, req, "fault lasts one cycle", int'(fault), 0);
    mem_cmp(req);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R10 watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    mth_valid = 1'b0;
    mth_sel   = 3'd0;
    mth_data  = 32'd0;
    lim_src   = 24'h800;
    lim_dst   = 24'hC00;
    for (int i = 0; i < MEMSZ; i++) gold[i] = pat(i);
    repeat (3) @(negedge clk);
    rst_n    = 1'b1;
    mem_fill = 1'b0;
    @(negedge clk);

    // R12 reset state
    chk(busy == 0, "R12", "busy after reset", int'(busy), 0);
    chk(done == 0 && fault == 0, "R12", "pulses after reset", int'({done, fault}), 0);
    chk(mth_ready == 1, "R12", "ready after reset", int'(mth_ready), 1);
    chk(!mem_rd_en && !mem_wr_en, "R12", "no traffic after reset", int'({mem_rd_en, mem_wr_en}), 0);

    // R12 / R4: format still zero after reset -> launch faults
    put(M_OP, 32'd3);
    put(M_SIZE, {16'd2, 16'd2});
    expect_fault("R12");

    // R2 R3 R7: 1 byte per pixel, distinct pitches and corners
    put(M_FMT, 32'h01);
    put(M_PITCH, {16'd32, 16'd16});
    put(M_SRCOFF, 32'h100);
    put(M_DSTOFF, 32'h400);
    put(M_PIN, {16'd1, 16'd2});
    put(M_POUT, {16'd2, 16'd3});
    model_copy(0, 16, 32, 'h100, 'h400, 2, 1, 3, 2, 5, 3);
    put(M_SIZE, {16'd3, 16'd5});
    chk(busy == 1, "R10", "busy after launch", int'(busy), 1);
    wait_done("R2");

    // R4: 4 bytes per pixel
    put(M_FMT, 32'h0A);
    put(M_PITCH, {16'd64, 16'd48});
    put(M_SRCOFF, 32'h200);
    put(M_DSTOFF, 32'h600);
    put(M_PIN, {16'd2, 16'd1});
    put(M_POUT, {16'd0, 16'd4});
    model_copy(2, 48, 64, 'h200, 'h600, 1, 2, 4, 0, 3, 2);
    put(M_SIZE, {16'd2, 16'd3});
    wait_done("R4");

    // R9: overlapping row, destination above source (top-down walk)
    put(M_FMT, 32'h01);
    put(M_PITCH, {16'd16, 16'd16});
    put(M_SRCOFF, 32'h300);
    put(M_DSTOFF, 32'h300);
    put(M_PIN, {16'd0, 16'd0});
    put(M_POUT, {16'd0, 16'd2});
    model_copy(0, 16, 16, 'h300, 'h300, 0, 0, 2, 0, 6, 2);
    put(M_SIZE, {16'd2, 16'd6});
    wait_done("R9");

    // R9: overlapping row, destination below source (bottom-up walk)
    put(M_PIN, {16'd1, 16'd3});
    put(M_POUT, {16'd1, 16'd0});
    model_copy(0, 16, 16, 'h300, 'h300, 3, 1, 0, 1, 7, 3);
    put(M_SIZE, {16'd3, 16'd7});
    wait_done("R9");

    // R11: empty extents
    put(M_SIZE, {16'd4, 16'd0});
    chk(done == 1, "R11", "done right after zero width", int'(done), 1);
    wait_done("R11");
    put(M_SIZE, {16'd0, 16'd3});
    chk(done == 1, "R11", "done right after zero height", int'(done), 1);
    wait_done("R11");

    // R5: wrong operation
    put(M_OP, 32'd4);
    put(M_SIZE, {16'd1, 16'd1});
    expect_fault("R5");
    put(M_OP, 32'd3);

    // R4: unknown format code
    put(M_FMT, 32'h02);
    put(M_SIZE, {16'd1, 16'd1});
    expect_fault("R4");
    put(M_FMT, 32'h01);

    // R6: limits
    put(M_SRCOFF, 32'h800);
    put(M_SIZE, {16'd1, 16'd1});
    expect_fault("R6");
    put(M_SRCOFF, 32'h7FF);
    put(M_DSTOFF, 32'hC00);
    put(M_SIZE, {16'd1, 16'd1});
    expect_fault("R6");
    put(M_DSTOFF, 32'hBFF);
    put(M_PIN, 32'd0);
    put(M_POUT, 32'd0);
    model_copy(0, 16, 16, 'h7FF, 'hBFF, 0, 0, 0, 0, 1, 1);
    put(M_SIZE, {16'd1, 16'd1});
    wait_done("R6");

    // R1: back-pressure while busy
    put(M_SRCOFF, 32'h100);
    put(M_DSTOFF, 32'h500);
    model_copy(0, 16, 16, 'h100, 'h500, 0, 0, 0, 0, 8, 4);
    put(M_SIZE, {16'd4, 16'd8});
    chk(mth_ready == 0, "R1", "ready low while busy", int'(mth_ready), 0);
    put(M_OP, 32'd5);
    chk(busy == 0, "R1", "held write accepted only when idle", int'(busy), 0);
    chk(q_rd.size() + q_wa.size() == 0, "R1", "copy finished before accept", q_rd.size() + q_wa.size(), 0);
    mem_cmp("R1");
    put(M_SIZE, {16'd1, 16'd1});
    expect_fault("R1");

    summary();
    $finish;
  end
endmodule